// File: doc/BRIEF.md
# Machine-Mode Double-Trap Guard

This block sits next to the machine-mode status state of a small hart and decides what happens to each trap request. It holds the trap-disable flag (MDT), the machine interrupt enable (MIE) and, when the resumable-NMI feature is built in, the NMI enable (NMIE). While MDT is clear, a trap goes to the ordinary machine handler, and taking it sets MDT so that a later trap can be recognised as re-entrant. A trap that arrives while MDT is already set, or while NMIE is clear, counts as unexpected. If NMIE is set, an unexpected trap is steered to the resumable NMI handler and its PC and cause are saved in the NMI-save registers. If NMIE is clear, or the NMI feature is absent, an unexpected trap freezes the hart in a sticky critical-error state that only reset clears.

The destination is reported combinationally in the cycle of the trap strobe. All status updates appear on the next clock edge. Software writes to the status fields arrive as three independent field writes, each with its own enable, so the block fits a layout where MDT and MIE share one register and a layout where they sit in separate halves.

Top module: `dtrap_ctrl`

## Requirements
- R1: Under synchronous reset MDT reads 1, while MIE, NMIE, crit_err, nmi_epc, nmi_cause and nmi_mpp all read 0.
- R2: A field write that sets MDT to 1 leaves MIE at 0 after the edge, whatever the same cycle writes to MIE.
- R3: A write of 1 to MIE takes effect only if MDT is 0 after that same cycle's writes, counting a same-cycle MDT write or else the current MDT. Otherwise MIE becomes 0. A write that changes MDT to 0 without writing MIE leaves MIE unchanged.
- R4: A trap request while MDT=0 and no NMI condition applies gives trap_dest=1 (machine handler) in the same cycle. After the edge MDT=1 and MIE=0.
- R5: A trap is unexpected when MDT=1, or when the NMI feature is present and NMIE=0.
- R6: An unexpected trap with NMIE=1 gives trap_dest=2 (NMI handler). After the edge nmi_epc holds the trap PC, nmi_cause holds the trap cause, nmi_mpp=2'b11 and NMIE=0, while MDT is unchanged.
- R7: An unexpected trap with NMIE=0 gives trap_dest=3 (halt). After the edge crit_err=1, and MDT and the NMI-save registers are unchanged.
- R8: crit_err stays 1 until reset. While it is 1, mie_o and nmie_o read 0, trap_dest reads 0, and trap, MRET and field-write inputs have no effect on any output.
- R9: An MRET strobe clears MDT to 0 at the next edge.
- R10: A trap request in the same cycle as field writes or MRET is served and they are discarded. MRET in the same cycle as field writes wins and the writes are discarded.
- R11: trap_dest reads 0 in any cycle without a trap request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mdt_en | input | 1 | Write enable for the MDT field |
| wr_mdt | input | 1 | Value written to MDT |
| wr_mie_en | input | 1 | Write enable for the MIE field |
| wr_mie | input | 1 | Value written to MIE |
| wr_nmie_en | input | 1 | Write enable for the NMIE field |
| wr_nmie | input | 1 | Value written to NMIE |
| trap_req | input | 1 | Trap request strobe |
| trap_cause | input | XLEN | Cause of the requested trap |
| trap_pc | input | XLEN | PC of the trapping instruction |
| mret | input | 1 | Return-from-machine-trap strobe |
| trap_dest | output | 2 | 0 none, 1 machine handler, 2 NMI handler, 3 halt |
| mdt_o | output | 1 | Current MDT |
| mie_o | output | 1 | Current MIE, masked during critical error |
| nmie_o | output | 1 | Current NMIE, masked during critical error |
| nmi_epc | output | XLEN | Saved PC of the redirected trap |
| nmi_cause | output | XLEN | Saved cause of the redirected trap |
| nmi_mpp | output | 2 | Previous-privilege field of the NMI status |
| crit_err | output | 1 | Sticky critical-error signal to the platform |

## Verification
The two functions that can collide are trap entry and a software update of the status fields or an MRET. The vector table drives a trap strobe together with a write that clears MDT and sets MIE, and checks that the trap is redirected while MDT stays 1 and MIE stays 0. A second vector pairs MRET with a write that sets MDT and expects MDT to end at 0. Inside the critical-error state, traps, writes and MRET are driven together, and the bench confirms that no output moves.

// File: rtl/dtrap_pkg.sv
package dtrap_pkg;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_MACH = 2'd1,
        DST_RNMI = 2'd2,
        DST_HALT = 2'd3
    } dest_e;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    typedef struct packed {
        logic mdt_en;
        logic mdt;
        logic mie_en;
        logic mie;
        logic nmie_en;
        logic nmie;
    } fld_wr_t;

    typedef struct packed {
        logic mdt;
        logic mie;
        logic nmie;
    } stat_t;

    // Where a trap goes, given the current guard state.
    function automatic dest_e pick_dest(input logic req, input logic halted,
                                        input logic mdt, input logic nmie,
                                        input logic has_nmi);
        if (!req || halted)                return DST_NONE;
        if (!mdt && (!has_nmi || nmie))    return DST_MACH;
        if (has_nmi && nmie)               return DST_RNMI;
        return DST_HALT;
    endfunction

    // MIE after a field write: forced low when MDT ends up set.
    function automatic logic mie_after(input fld_wr_t w, input logic cur_mdt,
                                       input logic cur_mie);
        if (w.mdt_en && w.mdt) return 1'b0;
        if (w.mie_en)          return w.mie && (w.mdt_en || !cur_mdt);
        return cur_mie;
    endfunction

endpackage

// File: rtl/dtrap_route.sv
module dtrap_route
    import dtrap_pkg::*;
#(
    parameter bit HAS_NMI = 1'b1
) (
    input  logic  req,
    input  logic  halted,
    input  stat_t st,
    output dest_e dest
);
    assign dest = pick_dest(req, halted, st.mdt, st.nmie, HAS_NMI);
endmodule

// File: rtl/dtrap_status.sv
module dtrap_status
    import dtrap_pkg::*;
#(
    parameter bit HAS_NMI = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    halted,
    input  dest_e   dest,
    input  logic    mret,
    input  fld_wr_t wr,
    output stat_t   st
);
    logic mdt_q, mie_q, nmie_q;
    logic trap_any;

    assign trap_any = (dest != DST_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mdt_q <= 1'b1;
            mie_q <= 1'b0;
        end else if (!halted) begin
            if (dest == DST_MACH) begin
                mdt_q <= 1'b1;
                mie_q <= 1'b0;
            end else if (trap_any) begin
                mdt_q <= mdt_q;
            end else if (mret) begin
                mdt_q <= 1'b0;
            end else begin
                if (wr.mdt_en) mdt_q <= wr.mdt;
                mie_q <= mie_after(wr, mdt_q, mie_q);
            end
        end
    end

    generate
        if (HAS_NMI) begin : g_nmie
            always_ff @(posedge clk) begin
                if (rst) begin
                    nmie_q <= 1'b0;
                end else if (!halted) begin
                    if (dest == DST_RNMI)
                        nmie_q <= 1'b0;
                    else if (!trap_any && !mret && wr.nmie_en)
                        nmie_q <= wr.nmie;
                end
            end
        end else begin : g_no_nmie
            logic unused_nmie_wr;
            assign unused_nmie_wr = wr.nmie_en ^ wr.nmie;
            assign nmie_q = 1'b0;
        end
    endgenerate

    assign st = '{mdt: mdt_q, mie: mie_q, nmie: nmie_q};
endmodule

// File: rtl/dtrap_nmisave.sv
module dtrap_nmisave
    import dtrap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit HAS_NMI = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  dest_e           dest,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] cause,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] cause_q,
    output logic [1:0]      mpp_q
);
    generate
        if (HAS_NMI) begin : g_save
            always_ff @(posedge clk) begin
                if (rst) begin
                    epc_q   <= '0;
                    cause_q <= '0;
                    mpp_q   <= '0;
                end else if (dest == DST_RNMI) begin
                    epc_q   <= pc;
                    cause_q <= cause;
                    mpp_q   <= PRIV_MACHINE;
                end
            end
        end else begin : g_nosave
            logic unused_save;
            assign unused_save = clk ^ rst ^ (^dest) ^ (^pc) ^ (^cause);
            assign epc_q   = '0;
            assign cause_q = '0;
            assign mpp_q   = '0;
        end
    endgenerate
endmodule

// File: rtl/dtrap_halt.sv
module dtrap_halt
    import dtrap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  dest_e dest,
    output logic  crit_q
);
    always_ff @(posedge clk) begin
        if (rst)
            crit_q <= 1'b0;
        else if (dest == DST_HALT)
            crit_q <= 1'b1;
    end
endmodule

// File: rtl/dtrap_ctrl.sv
module dtrap_ctrl
    import dtrap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit HAS_NMI = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_mdt_en,
    input  logic            wr_mdt,
    input  logic            wr_mie_en,
    input  logic            wr_mie,
    input  logic            wr_nmie_en,
    input  logic            wr_nmie,
    input  logic            trap_req,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_pc,
    input  logic            mret,
    output logic [1:0]      trap_dest,
    output logic            mdt_o,
    output logic            mie_o,
    output logic            nmie_o,
    output logic [XLEN-1:0] nmi_epc,
    output logic [XLEN-1:0] nmi_cause,
    output logic [1:0]      nmi_mpp,
    output logic            crit_err
);
    fld_wr_t wr;
    stat_t   st;
    dest_e   dest;
    logic    halted;

    assign wr = '{mdt_en: wr_mdt_en, mdt: wr_mdt, mie_en: wr_mie_en,
                  mie: wr_mie, nmie_en: wr_nmie_en, nmie: wr_nmie};

    dtrap_route #(.HAS_NMI(HAS_NMI)) u_route (
        .req(trap_req), .halted(halted), .st(st), .dest(dest)
    );

    dtrap_status #(.HAS_NMI(HAS_NMI)) u_status (
        .clk(clk), .rst(rst), .halted(halted), .dest(dest),
        .mret(mret), .wr(wr), .st(st)
    );

    dtrap_nmisave #(.XLEN(XLEN), .HAS_NMI(HAS_NMI)) u_save (
        .clk(clk), .rst(rst), .dest(dest), .pc(trap_pc), .cause(trap_cause),
        .epc_q(nmi_epc), .cause_q(nmi_cause), .mpp_q(nmi_mpp)
    );

    dtrap_halt u_halt (
        .clk(clk), .rst(rst), .dest(dest), .crit_q(halted)
    );

    assign trap_dest = dest;
    assign mdt_o     = st.mdt;
    assign mie_o     = st.mie  & ~halted;
    assign nmie_o    = st.nmie & ~halted;
    assign crit_err  = halted;
endmodule

// File: rtl/dtrap_ctrl_chk.sv
module dtrap_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_mdt_en,
    input logic            wr_mdt,
    input logic            trap_req,
    input logic [XLEN-1:0] trap_pc,
    input logic            mret,
    input logic [1:0]      trap_dest,
    input logic            mdt_o,
    input logic            mie_o,
    input logic            nmie_o,
    input logic [XLEN-1:0] nmi_epc,
    input logic [1:0]      nmi_mpp,
    input logic            crit_err
);
    // R2
    mdt_set_clears_mie_chk: assert property (@(posedge clk) disable iff (rst)
        (!crit_err && !trap_req && !mret && wr_mdt_en && wr_mdt) |=> !mie_o);

    // R4
    mach_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_dest == 2'd1) |=> (mdt_o && !mie_o));

    // R5
    unexpected_route_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !crit_err && mdt_o) |-> (trap_dest == 2'd2 || trap_dest == 2'd3));

    // R6
    rnmi_save_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_dest == 2'd2) |=> (!nmie_o && nmi_mpp == 2'b11 && nmi_epc == $past(trap_pc)));

    // R7
    halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_dest == 2'd3) |=> crit_err);

    // R8
    crit_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        crit_err |=> crit_err);

    // R8
    crit_mask_chk: assert property (@(posedge clk) disable iff (rst)
        crit_err |-> (trap_dest == 2'd0 && !mie_o && !nmie_o));

    // R9
    mret_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mret && !trap_req && !crit_err) |=> !mdt_o);

    // R11
    idle_dest_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_req |-> (trap_dest == 2'd0));
endmodule

bind dtrap_ctrl dtrap_ctrl_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst(rst), .wr_mdt_en(wr_mdt_en), .wr_mdt(wr_mdt),
    .trap_req(trap_req), .trap_pc(trap_pc), .mret(mret),
    .trap_dest(trap_dest), .mdt_o(mdt_o), .mie_o(mie_o), .nmie_o(nmie_o),
    .nmi_epc(nmi_epc), .nmi_mpp(nmi_mpp), .crit_err(crit_err)
);

// File: tb/dtrap_ctrl_tb.sv
module dtrap_ctrl_tb;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst;
    logic wr_mdt_en, wr_mdt, wr_mie_en, wr_mie, wr_nmie_en, wr_nmie;
    logic trap_req, mret;
    logic [XLEN-1:0] trap_cause, trap_pc;
    logic [1:0] trap_dest, nmi_mpp;
    logic mdt_o, mie_o, nmie_o, crit_err;
    logic [XLEN-1:0] nmi_epc, nmi_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dtrap_ctrl #(.XLEN(XLEN), .HAS_NMI(1'b1)) u_dut (
        .clk(clk), .rst(rst),
        .wr_mdt_en(wr_mdt_en), .wr_mdt(wr_mdt), .wr_mie_en(wr_mie_en), .wr_mie(wr_mie),
        .wr_nmie_en(wr_nmie_en), .wr_nmie(wr_nmie),
        .trap_req(trap_req), .trap_cause(trap_cause), .trap_pc(trap_pc), .mret(mret),
        .trap_dest(trap_dest), .mdt_o(mdt_o), .mie_o(mie_o), .nmie_o(nmie_o),
        .nmi_epc(nmi_epc), .nmi_cause(nmi_cause), .nmi_mpp(nmi_mpp), .crit_err(crit_err)
    );

    typedef struct packed {
        logic [31:0] tag;
        logic m_en, m, i_en, i, n_en, n, trap, ret;
        logic [1:0] xdest;
        logic xmdt, xmie, xnmie;
    } vec_t;

    // inputs: mdt_en mdt mie_en mie nmie_en nmie trap mret | dest mdt mie nmie after
    localparam vec_t VECS [13] = '{
        '{"R3  ", 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,1'b0,1'b0},
        '{"R3  ", 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b1,1'b0},
        '{"R2  ", 1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,1'b0,1'b0},
        '{"R3  ", 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0},
        '{"R3  ", 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b1,1'b0},
        '{"R2  ", 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,1'b0,1'b0},
        '{"R9  ", 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 2'd0,1'b0,1'b0,1'b0},
        '{"R3  ", 1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b1,1'b1},
        '{"R4  ", 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 2'd1,1'b1,1'b0,1'b1},
        '{"R6  ", 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 2'd2,1'b1,1'b0,1'b0},
        '{"R10 ", 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 2'd0,1'b0,1'b0,1'b0},
        '{"R11 ", 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b1},
        '{"R4  ", 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 2'd1,1'b1,1'b0,1'b1}
    };

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_mdt_en = 0; wr_mdt = 0; wr_mie_en = 0; wr_mie = 0;
        wr_nmie_en = 0; wr_nmie = 0; trap_req = 0; mret = 0;
        trap_cause = '0; trap_pc = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; idle();
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    // step: inputs already driven at a negedge; sample dest, advance one edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_up();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 mdt", mdt_o, 1);
        check("R1 mie", mie_o, 0);
        check("R1 nmie", nmie_o, 0);
        check("R1 crit", crit_err, 0);
        check("R1 epc", nmi_epc, 0);
        check("R1 cause", nmi_cause, 0);
        check("R1 mpp", nmi_mpp, 0);

        for (int k = 0; k < 13; k++) begin
            vec_t v;
            v = VECS[k];
            wr_mdt_en = v.m_en; wr_mdt = v.m; wr_mie_en = v.i_en; wr_mie = v.i;
            wr_nmie_en = v.n_en; wr_nmie = v.n; trap_req = v.trap; mret = v.ret;
            trap_pc = 32'h1000 + 32'(k) * 4; trap_cause = 32'(k);
            #1;
            check($sformatf("%s v%0d dest", v.tag, k), trap_dest, v.xdest);
            step();
            check($sformatf("%s v%0d mdt", v.tag, k), mdt_o, v.xmdt);
            check($sformatf("%s v%0d mie", v.tag, k), mie_o, v.xmie);
            check($sformatf("%s v%0d nmie", v.tag, k), nmie_o, v.xnmie);
            if (v.xdest == 2'd2) begin
                check("R6 epc", nmi_epc, 32'h1000 + 32'(k) * 4);
                check("R6 cause", nmi_cause, 32'(k));
                check("R6 mpp", nmi_mpp, 2'b11);
            end
            idle();
        end

        // R5 / R7: MDT=0 but NMIE=0 -> halt
        mret = 1; step(); idle();
        wr_nmie_en = 1; wr_nmie = 0; step(); idle();
        check("R7 pre mdt", mdt_o, 0);
        trap_req = 1; trap_pc = 32'hBEEF0; trap_cause = 32'd5;
        #1;
        check("R5 nmie0 dest", trap_dest, 2'd3);
        step(); idle();
        check("R7 crit", crit_err, 1);
        check("R7 epc kept", nmi_epc, 32'h1024);
        check("R7 cause kept", nmi_cause, 32'd9);
        check("R7 mdt kept", mdt_o, 0);
        check("R8 mie masked", mie_o, 0);
        check("R8 nmie masked", nmie_o, 0);

        // R8: everything ignored while halted
        trap_req = 1; trap_pc = 32'h4444; trap_cause = 32'd7;
        wr_mdt_en = 1; wr_mdt = 1; wr_nmie_en = 1; wr_nmie = 1;
        #1;
        check("R8 dest none", trap_dest, 2'd0);
        step(); idle();
        mret = 1; step(); idle();
        wr_mdt_en = 1; wr_mdt = 1; wr_mie_en = 1; wr_mie = 1; step(); idle();
        check("R8 crit sticky", crit_err, 1);
        check("R8 mdt frozen", mdt_o, 0);
        check("R8 epc frozen", nmi_epc, 32'h1024);
        check("R8 mie masked", mie_o, 0);

        // R1 reset leaves halt; then R5 with MDT=1
        do_reset();
        check("R1 crit cleared", crit_err, 0);
        check("R1 mdt", mdt_o, 1);
        check("R1 epc", nmi_epc, 0);
        wr_nmie_en = 1; wr_nmie = 1; step(); idle();
        trap_req = 1; trap_pc = 32'h2000; trap_cause = 32'd3;
        #1;
        check("R5 mdt1 dest", trap_dest, 2'd2);
        step(); idle();
        check("R6 epc", nmi_epc, 32'h2000);
        check("R6 mdt kept", mdt_o, 1);
        #1;
        check("R11 idle dest", trap_dest, 2'd0);

        done = 1'b1;
        finish_up();
    end
endmodule